// File: doc/BRIEF.md
# Frame sync pulse generator

This block produces the frame-sync strobes for a group of voice codecs sharing a serial data highway. It runs on the highway bit clock and keeps two position counters, one for the transmit frame and one for the receive frame. Each counter restarts when its own slot-0 sync pulse is seen, and otherwise steps through a frame of 64 slots of 8 bit periods each. Eight strobe outputs (four transmit, four receive) each go high for exactly one slot when the frame position reaches the slot held in that output's entry of an assignment table. An active-low busy output shows whether any transmit strobe is active.

A reference-select input picks between two arrangements. With the input high, receive strobes follow the receive counter. With it low, all eight strobes follow the transmit counter, and the receive sync pin is ignored. In the second arrangement the same pin can carry a channel-select bit to a control decoder elsewhere. The table is written by that decoder, which is outside this block. A change to an entry is held back until the next slot boundary of the entry's reference.

Top module: `fsync_gen`

## Requirements
- R1: While rst_n is low, every strobe output is low and tx_busy_n is high.
- R2: Position counts bit periods from 0 to 511. A rising edge that samples the sync input high starts position 0 (slot 0, bit 0); each later rising edge adds one. The slot is position divided by 8. A strobe is high during the cycles whose slot equals its entry's 6-bit slot field, which is 8 consecutive cycles.
- R3: An output whose valid bit is 0 stays low. Table entry i uses asg_valid[i] and asg_slot[6*i+5:6*i]. Entries 0 to 3 drive fs_tx[0..3], and entries 4 to 7 drive fs_rx[0..3].
- R4: With mode_split = 1, transmit strobes are timed from tx_sync and receive strobes from rx_sync, each independently.
- R5: With mode_split = 0, all eight strobes are timed from tx_sync, and rx_sync has no effect on any output.
- R6: With no sync pulse, a counter wraps from position 511 (slot 63, bit 7) to position 0.
- R7: A sync pulse sampled mid-frame restarts its counter at position 0 on that same edge.
- R8: The table is sampled only on rising edges after which a new slot begins. The new slot can start because the previous bit was bit 7, or because a sync pulse was sampled. A change made inside a slot first affects the next slot, so no strobe is cut short or stretched by a table write.
- R9: tx_busy_n is low exactly when at least one fs_tx bit is high.
- R10: Outputs change only at falling edges of bclk. They reflect the position that the preceding rising edge started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | 1: separate receive reference, 0: all strobes from transmit reference |
| tx_sync | input | 1 | Transmit slot-0 sync, sampled on rising bclk |
| rx_sync | input | 1 | Receive slot-0 sync, sampled on rising bclk |
| asg_valid | input | 8 | Valid bit per table entry |
| asg_slot | input | 48 | 6-bit assigned slot per table entry |
| fs_tx | output | 4 | Transmit frame-sync strobes |
| fs_rx | output | 4 | Receive frame-sync strobes |
| tx_busy_n | output | 1 | Low while any transmit strobe is high |

## Verification
On every cycle, the embedded properties check four things. Each counter either restarts on a sampled sync or steps by one, with wrap. A lane's latched entry changes only on a slot-start edge. A strobe is never high without a valid entry, and it rises or falls only at bit 0. The busy output tracks the transmit strobes. Other behaviour shows only in the bench's scenarios, because it needs the whole table and frame history: pulses landing in the right slot for every slot value, independent receive and transmit phase, rx_sync being ignored in shared mode, and a mid-slot table write taking effect at the next slot.

// File: rtl/fsync_pkg.sv
`timescale 1ns/1ps
package fsync_pkg;

  typedef enum logic {
    REF_SHARED = 1'b0,
    REF_SPLIT  = 1'b1
  } ref_mode_e;

  // next frame position, wrapping at the frame length
  function automatic int pos_step(int pos, int frame_len);
    if (pos >= frame_len - 1) return 0;
    return pos + 1;
  endfunction

  function automatic int slot_of(int pos, int slot_cyc);
    return pos / slot_cyc;
  endfunction

  function automatic int bit_of(int pos, int slot_cyc);
    return pos % slot_cyc;
  endfunction

  function automatic logic is_last_bit(int pos, int slot_cyc);
    return (pos % slot_cyc) == (slot_cyc - 1);
  endfunction

endpackage

// File: rtl/fsync_slot_counter.sv
`timescale 1ns/1ps
module fsync_slot_counter
  import fsync_pkg::*;
#(
  parameter int SLOT_CYC  = 8,
  parameter int NUM_SLOTS = 64,
  parameter int POS_W     = 9,
  parameter int SLOT_W    = 6,
  parameter int BIT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              load_o
);

  localparam int FRAME_LEN = SLOT_CYC * NUM_SLOTS;

  logic [POS_W-1:0] pos_q;
  logic             started_q;
  logic             last_bit;

  assign last_bit = is_last_bit(int'(pos_q), SLOT_CYC);
  assign slot_o   = SLOT_W'(slot_of(int'(pos_q), SLOT_CYC));
  assign bit_o    = BIT_W'(bit_of(int'(pos_q), SLOT_CYC));
  // the coming rising edge begins a new slot
  assign load_o   = sync | last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= POS_W'(FRAME_LEN - 1);
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (sync) pos_q <= '0;
      else      pos_q <= POS_W'(pos_step(int'(pos_q), FRAME_LEN));
    end
  end

  // R7: a sampled sync restarts the frame at position 0
  a_r7_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(sync)) |-> (pos_q == '0));

  // R6: without sync the position advances by one, wrapping at the frame end
  a_r6_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !$past(sync)) |->
      (int'(pos_q) == pos_step(int'($past(pos_q)), FRAME_LEN)));

endmodule

// File: rtl/fsync_lane.sv
`timescale 1ns/1ps
module fsync_lane #(
  parameter int SLOT_W = 6,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cfg_valid,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [BIT_W-1:0]  cur_bit,
  output logic              match_o,
  output logic              fs_o
);

  logic              sh_valid_q;
  logic [SLOT_W-1:0] sh_slot_q;
  logic              fs_q;

  // shadow copy of the table entry, refreshed only at slot starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_valid_q <= 1'b0;
      sh_slot_q  <= '0;
    end else if (load) begin
      sh_valid_q <= cfg_valid;
      sh_slot_q  <= cfg_slot;
    end
  end

  assign match_o = sh_valid_q && (cur_slot == sh_slot_q);

  // strobe launched from the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= match_o;
  end

  assign fs_o = fs_q;

  // R8: the latched entry holds between slot starts
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(sh_valid_q) && $stable(sh_slot_q)));

  // R3: a strobe is never high without a valid entry
  a_r3_valid_needed: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> sh_valid_q);

  // R2: strobe edges fall on slot boundaries only
  a_r2_rise_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_q) |-> (cur_bit == '0));

  a_r2_fall_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_q) |-> (cur_bit == '0));

endmodule

// File: rtl/fsync_gen.sv
`timescale 1ns/1ps
module fsync_gen
  import fsync_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SLOT_CYC  = 8,
  parameter int NUM_SLOTS = 64
) (
  input  logic                                  bclk,
  input  logic                                  rst_n,
  input  logic                                  mode_split,
  input  logic                                  tx_sync,
  input  logic                                  rx_sync,
  input  logic [2*LANES-1:0]                    asg_valid,
  input  logic [2*LANES*$clog2(NUM_SLOTS)-1:0]  asg_slot,
  output logic [LANES-1:0]                      fs_tx,
  output logic [LANES-1:0]                      fs_rx,
  output logic                                  tx_busy_n
);

  localparam int POS_W  = $clog2(SLOT_CYC * NUM_SLOTS);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int BIT_W  = $clog2(SLOT_CYC);
  localparam int NOUT   = 2 * LANES;

  ref_mode_e ref_mode;
  assign ref_mode = ref_mode_e'(mode_split);

  logic [SLOT_W-1:0] tx_slot, rx_slot, rxr_slot;
  logic [BIT_W-1:0]  tx_bit, rx_bit, rxr_bit;
  logic              tx_load, rx_load, rxr_load;

  fsync_slot_counter #(
    .SLOT_CYC(SLOT_CYC), .NUM_SLOTS(NUM_SLOTS),
    .POS_W(POS_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
  ) u_tx_cnt (
    .clk(bclk), .rst_n(rst_n), .sync(tx_sync),
    .slot_o(tx_slot), .bit_o(tx_bit), .load_o(tx_load)
  );

  fsync_slot_counter #(
    .SLOT_CYC(SLOT_CYC), .NUM_SLOTS(NUM_SLOTS),
    .POS_W(POS_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
  ) u_rx_cnt (
    .clk(bclk), .rst_n(rst_n), .sync(rx_sync),
    .slot_o(rx_slot), .bit_o(rx_bit), .load_o(rx_load)
  );

  // receive lanes follow their own counter only in split mode
  always_comb begin
    if (ref_mode == REF_SPLIT) begin
      rxr_slot = rx_slot;
      rxr_bit  = rx_bit;
      rxr_load = rx_load;
    end else begin
      rxr_slot = tx_slot;
      rxr_bit  = tx_bit;
      rxr_load = tx_load;
    end
  end

  logic [NOUT-1:0] lane_match;
  logic [NOUT-1:0] lane_fs;

  for (genvar g = 0; g < NOUT; g++) begin : g_lane
    logic              l_load;
    logic [SLOT_W-1:0] l_slot;
    logic [BIT_W-1:0]  l_bit;
    if (g < LANES) begin : g_tx
      assign l_load = tx_load;
      assign l_slot = tx_slot;
      assign l_bit  = tx_bit;
    end else begin : g_rx
      assign l_load = rxr_load;
      assign l_slot = rxr_slot;
      assign l_bit  = rxr_bit;
    end
    fsync_lane #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_lane (
      .clk(bclk), .rst_n(rst_n), .load(l_load),
      .cfg_valid(asg_valid[g]),
      .cfg_slot(asg_slot[g*SLOT_W +: SLOT_W]),
      .cur_slot(l_slot), .cur_bit(l_bit),
      .match_o(lane_match[g]), .fs_o(lane_fs[g])
    );
  end

  logic busy_n_q;
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) busy_n_q <= 1'b1;
    else        busy_n_q <= ~|lane_match[LANES-1:0];
  end

  assign fs_tx     = lane_fs[LANES-1:0];
  assign fs_rx     = lane_fs[NOUT-1:LANES];
  assign tx_busy_n = busy_n_q;

  // R9: busy indicator agrees with the transmit strobes
  a_r9_busy_tracks: assert property (@(posedge bclk) disable iff (!rst_n)
    tx_busy_n == !(|fs_tx));

endmodule

// File: tb/fsync_gen_bench.sv
`timescale 1ns/1ps
module fsync_gen_bench;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_mode = 1'b1;
  logic        d_txs = 1'b0;
  logic        d_rxs = 1'b0;
  logic [7:0]  d_valid = '0;
  logic [47:0] d_slot = '0;
  logic [3:0]  fs_tx, fs_rx;
  logic        tx_busy_n;

  always #4 bclk = ~bclk;

  fsync_gen u_fsync_gen (
    .bclk(bclk), .rst_n(rst_n), .mode_split(d_mode),
    .tx_sync(d_txs), .rx_sync(d_rxs),
    .asg_valid(d_valid), .asg_slot(d_slot),
    .fs_tx(fs_tx), .fs_rx(fs_rx), .tx_busy_n(tx_busy_n)
  );

  int total = 0;
  int bad = 0;
  string tag = "R2";

  int t_tx, t_rx;
  logic       mv [8];
  int         ms [8];
  logic [7:0] prev_exp;

  task automatic chk(string rq, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0;
    d_mode = mode; d_txs = 0; d_rxs = 0; d_valid = '0; d_slot = '0;
    repeat (2) @(posedge bclk);
    #5;
    chk("R1", "fs_tx", fs_tx, 0);
    chk("R1", "fs_rx", fs_rx, 0);
    chk("R1", "busy_n", tx_busy_n, 1);
    t_tx = 511; t_rx = 511;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; ms[i] = 0; end
    prev_exp = '0;
    rst_n = 1'b1;
  endtask

  task automatic cyc();
    logic       bt, br, b;
    logic [7:0] e;
    int         r;
    @(posedge bclk);
    #1;
    chk("R10", "hold_at_rise", {fs_rx, fs_tx}, prev_exp);
    bt = d_txs || (t_tx % 8 == 7);
    br = d_rxs || (t_rx % 8 == 7);
    t_tx = d_txs ? 0 : (t_tx + 1) % 512;
    t_rx = d_rxs ? 0 : (t_rx + 1) % 512;
    for (int i = 0; i < 8; i++) begin
      b = (i >= 4 && d_mode) ? br : bt;
      if (b) begin
        mv[i] = d_valid[i];
        ms[i] = (d_slot >> (6 * i)) & 63;
      end
      r = (i >= 4 && d_mode) ? t_rx : t_tx;
      e[i] = mv[i] && (ms[i] == r / 8);
    end
    #4;
    chk(tag, "fs_tx", fs_tx, e[3:0]);
    chk(tag, "fs_rx", fs_rx, e[7:4]);
    chk("R9", "busy_n", tx_busy_n, !(|e[3:0]));
    prev_exp = e;
  endtask

  task automatic set_entry(int i, logic v, int s);
    d_valid[i] = v;
    d_slot[6*i +: 6] = 6'(s);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b1);

    // R2/R3/R4: split references, rx phase offset from tx
    set_entry(0, 1, 0);  set_entry(1, 1, 5);
    set_entry(2, 1, 63); set_entry(3, 0, 5);
    set_entry(4, 1, 1);  set_entry(5, 1, 63);
    set_entry(6, 1, 5);  set_entry(7, 0, 2);
    tag = "R2";
    d_txs = 1; cyc(); d_txs = 0;
    repeat (99) cyc();
    tag = "R4";
    d_rxs = 1; cyc(); d_rxs = 0;
    repeat (600) cyc();
    // R6: frames roll over without new syncs
    tag = "R6";
    repeat (1100) cyc();

    // R7: syncs arriving mid-frame and mid-slot
    tag = "R7";
    repeat (37) cyc();
    d_txs = 1; cyc(); d_txs = 0;
    repeat (203) cyc();
    d_rxs = 1; cyc(); d_rxs = 0;
    repeat (11) cyc();
    d_txs = 1; cyc(); d_txs = 0;
    repeat (600) cyc();

    // R3: all entries invalid for a full frame
    tag = "R3";
    d_valid = '0;
    repeat (520) cyc();

    // R8 + R2 sweep: table rewritten inside a slot each frame
    for (int s = 0; s < 64; s++) begin
      while (t_tx % 8 != 3) cyc();
      tag = "R8";
      for (int i = 0; i < 8; i++)
        set_entry(i, ((s + i) % 3) != 0 || i == 0, (s * 5 + i * 13) % 64);
      repeat (16) cyc();
      tag = "R2";
      repeat (500) cyc();
    end

    // R5: shared reference, rx_sync toggling with no effect
    do_reset(1'b0);
    tag = "R5";
    for (int i = 0; i < 8; i++) set_entry(i, 1, (i * 9 + 2) % 64);
    d_txs = 1; cyc(); d_txs = 0;
    for (int n = 0; n < 1100; n++) begin
      d_rxs = ~d_rxs;
      cyc();
    end
    for (int s = 0; s < 8; s++) begin
      while (t_tx % 8 != 5) begin d_rxs = ~d_rxs; cyc(); end
      for (int i = 0; i < 8; i++) set_entry(i, (s + i) % 4 != 1, (s * 7 + i * 11) % 64);
      for (int n = 0; n < 512; n++) begin d_rxs = (n % 3 == 0); cyc(); end
    end
    d_rxs = 0;
    d_txs = 1; cyc(); d_txs = 0;
    repeat (300) cyc();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule